// File: doc/BRIEF.md
# Sub-Source Interrupt Fan-In Stage

This block sits in front of a main interrupt controller and condenses many second-level interrupt events onto a small set of first-level request lines. It holds two banks of second-level state. The internal bank has 15 sub-sources. The external bank has 20 lines, numbered 4 to 23. Each bank has a pending register and a mask register.

An event pulse sets its pending bit whether or not that bit is masked. The pending bits that are unmasked are ORed per group and registered onto level request lines. Software clears a pending bit by writing 1 to it over a plain register write port. A level request keeps asserting for as long as any unmasked pending bit in its group is set. A downstream first-level pending bit that is cleared early is therefore set again at once. Software has to clear the second-level bit first and the first-level bit after it.

The register port is a single-cycle write strobe with a combinational read. It has no handshake, because every access completes in the cycle it is issued. Internal sub-sources are grouped in consecutive runs of three: bits 0-2 form group 0, bits 3-5 form group 1, and so on up to group 4. External bank bit k stands for line k+4. Lines 4-7 (bits 0-3) drive the low external request, and lines 8-23 (bits 4-19) drive the high external request.

Top module: `subirq_fanin`

## Requirements
- R1: After reset, both pending registers read 0, the internal mask reads 0x7FFF, the external mask reads 0xFFFFF, and all request outputs are 0.
- R2: An event pulse on a sub-source or an external line sets its pending bit at the next clock edge, regardless of the mask; the bit is visible on the read port after that edge.
- R3: A write to a pending register (address 0 = internal, address 2 = external) clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit is set after that edge.
- R5: A write to a mask register (address 1 = internal, address 3 = external) replaces its whole content; a mask bit of 1 blocks that source, and 0 lets it through.
- R6: Each request output equals the OR of (pending AND NOT mask) over its group, as that state stood one clock edge earlier.
- R7: Internal pending bit i drives sub_req_o[i/3], giving five internal request lines.
- R8: External lines 4-7 (bank bits 0-3) drive ext_req_o[0], and lines 8-23 (bank bits 4-19) drive ext_req_o[1].
- R9: A request stays asserted on every cycle while any unmasked pending bit of its group remains set, and it drops one cycle after the last such bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_evt_i | input | 15 | Internal sub-source event pulses, one per bit |
| ext_evt_i | input | 20 | External line event pulses, bit k = line k+4 |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address: 0 int pend, 1 int mask, 2 ext pend, 3 ext mask |
| reg_wdata_i | input | 20 | Write data |
| reg_raddr_i | input | 2 | Read address, same encoding as the write address |
| reg_rdata_o | output | 20 | Read data, zero-extended, combinational |
| sub_req_o | output | 5 | Internal group request lines |
| ext_req_o | output | 2 | External group request lines (0: lines 4-7, 1: lines 8-23) |

## Verification
A pending bit that is lost or stuck is visible on the read port right after the edge where it should have changed. When that bit is unmasked, it also shows on the group request exactly one cycle later. A wrong grouping or mask polarity asserts or drops the wrong request line, again one cycle after the state changes. The bench reads all four registers and compares every request line on every cycle, so each such error is reported in the cycle it first appears.

// File: rtl/subirq_pkg.sv
package subirq_pkg;
  // default geometry of the two banks
  localparam int unsigned SUB_W_D    = 15;
  localparam int unsigned SUB_GSZ_D  = 3;
  localparam int unsigned EXT_W_D    = 20;
  localparam int unsigned EXT_LO_W_D = 4;

  // register address encoding
  typedef enum logic [1:0] {
    A_SUB_PEND = 2'd0,
    A_SUB_MASK = 2'd1,
    A_EXT_PEND = 2'd2,
    A_EXT_MASK = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] mask_q;

  // one sticky cell per source; a new event outranks a clear
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[i] <= 1'b0;
      else if (evt_i[i])
        pend_q[i] <= 1'b1;
      else if (clr_i[i])
        pend_q[i] <= 1'b0;
    end

    // R2 / R4: an event always leaves the bit set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> pend_q[i]);
    // R3: a clear without an event empties the bit
    p_clr_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !pend_q[i]);
    // R3: without a clear a set bit holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (mask_we_i)
      mask_q <= mask_d_i;
  end

  // R5: the mask only moves on a write
  p_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_q));

  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int unsigned W  = 15,
  parameter int unsigned NG = 5,
  parameter logic [NG*W-1:0] SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  mask_i,
  output logic [NG-1:0] req_o
);
  logic [W-1:0]  live;
  logic [NG-1:0] req_q;

  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit;
    assign hit = |(live & SEL[g*W +: W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        req_q[g] <= 1'b0;
      else
        req_q[g] <= hit;
    end

    // R6 / R9: the request follows group state one edge later
    p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_i & ~mask_i & SEL[g*W +: W])) |=> req_o[g]);
    p_req_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend_i & ~mask_i & SEL[g*W +: W])) |=> !req_o[g]);
  end

  assign req_o = req_q;
endmodule

// File: rtl/subirq_fanin.sv
module subirq_fanin
  import subirq_pkg::*;
#(
  parameter int unsigned SUB_W    = SUB_W_D,
  parameter int unsigned SUB_GSZ  = SUB_GSZ_D,
  parameter int unsigned EXT_W    = EXT_W_D,
  parameter int unsigned EXT_LO_W = EXT_LO_W_D,
  localparam int unsigned SUB_NG  = (SUB_W + SUB_GSZ - 1) / SUB_GSZ,
  localparam int unsigned EXT_NG  = 2,
  localparam int unsigned DW      = (SUB_W > EXT_W) ? SUB_W : EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  sub_evt_i,
  input  logic [EXT_W-1:0]  ext_evt_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [1:0]        reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [SUB_NG-1:0] sub_req_o,
  output logic [EXT_NG-1:0] ext_req_o
);
  // membership of each internal group: consecutive runs of SUB_GSZ
  function automatic logic [SUB_NG*SUB_W-1:0] sub_sel_f();
    logic [SUB_NG*SUB_W-1:0] s;
    s = '0;
    for (int i = 0; i < int'(SUB_W); i++)
      s[(i / int'(SUB_GSZ)) * int'(SUB_W) + i] = 1'b1;
    return s;
  endfunction

  // external: first EXT_LO_W bits to group 0, the rest to group 1
  function automatic logic [EXT_NG*EXT_W-1:0] ext_sel_f();
    logic [EXT_NG*EXT_W-1:0] s;
    s = '0;
    for (int i = 0; i < int'(EXT_W); i++)
      if (i < int'(EXT_LO_W)) s[i] = 1'b1;
      else                    s[int'(EXT_W) + i] = 1'b1;
    return s;
  endfunction

  localparam logic [SUB_NG*SUB_W-1:0] SUB_SEL = sub_sel_f();
  localparam logic [EXT_NG*EXT_W-1:0] EXT_SEL = ext_sel_f();

  logic [SUB_W-1:0] sub_clr, sub_pend, sub_mask;
  logic [EXT_W-1:0] ext_clr, ext_pend, ext_mask;
  logic             sub_mask_we, ext_mask_we;

  // write decode: pending registers take write-1-to-clear
  always_comb begin
    sub_clr     = '0;
    ext_clr     = '0;
    sub_mask_we = 1'b0;
    ext_mask_we = 1'b0;
    if (reg_we_i) begin
      unique case (reg_addr_e'(reg_waddr_i))
        A_SUB_PEND: sub_clr     = reg_wdata_i[SUB_W-1:0];
        A_SUB_MASK: sub_mask_we = 1'b1;
        A_EXT_PEND: ext_clr     = reg_wdata_i[EXT_W-1:0];
        A_EXT_MASK: ext_mask_we = 1'b1;
        default: ;
      endcase
    end
  end

  irq_pend_bank #(.W(SUB_W)) u_sub_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (sub_evt_i),
    .clr_i    (sub_clr),
    .mask_we_i(sub_mask_we),
    .mask_d_i (reg_wdata_i[SUB_W-1:0]),
    .pend_o   (sub_pend),
    .mask_o   (sub_mask)
  );

  irq_pend_bank #(.W(EXT_W)) u_ext_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (ext_evt_i),
    .clr_i    (ext_clr),
    .mask_we_i(ext_mask_we),
    .mask_d_i (reg_wdata_i[EXT_W-1:0]),
    .pend_o   (ext_pend),
    .mask_o   (ext_mask)
  );

  irq_group_or #(.W(SUB_W), .NG(SUB_NG), .SEL(SUB_SEL)) u_sub_or (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(sub_pend),
    .mask_i(sub_mask),
    .req_o (sub_req_o)
  );

  irq_group_or #(.W(EXT_W), .NG(EXT_NG), .SEL(EXT_SEL)) u_ext_or (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(ext_pend),
    .mask_i(ext_mask),
    .req_o (ext_req_o)
  );

  // combinational read, zero-extended to DW
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_raddr_i))
      A_SUB_PEND: reg_rdata_o[SUB_W-1:0] = sub_pend;
      A_SUB_MASK: reg_rdata_o[SUB_W-1:0] = sub_mask;
      A_EXT_PEND: reg_rdata_o[EXT_W-1:0] = ext_pend;
      A_EXT_MASK: reg_rdata_o[EXT_W-1:0] = ext_mask;
      default: ;
    endcase
  end

  // R9: a fully masked bank raises no request on the next edge
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&sub_mask) |=> (sub_req_o == '0));
  // R5: an external mask write lands on the next edge
  p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mask_we |=> (ext_mask == $past(reg_wdata_i[EXT_W-1:0])));
endmodule

// File: tb/subirq_fanin_bench.sv
`timescale 1ns/1ps
module subirq_fanin_bench;
  localparam int SW = 15, EW = 20, NG = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sub_evt = '0;
  logic [EW-1:0] ext_evt = '0;
  logic          we = 1'b0;
  logic [1:0]    waddr = '0, raddr = '0;
  logic [EW-1:0] wdata = '0;
  logic [EW-1:0] rdata;
  logic [NG-1:0] sub_req;
  logic [1:0]    ext_req;

  int vectors = 0, misses = 0;

  // model state
  logic [SW-1:0] m_sp, m_sm;
  logic [EW-1:0] m_ep, m_em;
  logic [NG-1:0] m_sr;
  logic [1:0]    m_er;

  always #4 clk = ~clk;

  subirq_fanin u_subirq_fanin (
    .clk(clk), .rst_n(rst_n), .sub_evt_i(sub_evt), .ext_evt_i(ext_evt),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .sub_req_o(sub_req), .ext_req_o(ext_req));

  function automatic logic [NG-1:0] f_sub_req(logic [SW-1:0] p, logic [SW-1:0] m);
    logic [NG-1:0] r;
    logic [SW-1:0] l;
    l = p & ~m;
    r = '0;
    for (int i = 0; i < SW; i++) if (l[i]) r[i / 3] = 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] f_ext_req(logic [EW-1:0] p, logic [EW-1:0] m);
    logic [EW-1:0] l;
    l = p & ~m;
    return {|l[EW-1:4], |l[3:0]};
  endfunction

  task automatic chk(string tag, string what, logic [EW-1:0] act, logic [EW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called just after a negedge: compare requests and all four registers
  task automatic check_all(string tag);
    chk(tag, "sub_req", EW'(sub_req), EW'(m_sr));
    chk(tag, "ext_req", EW'(ext_req), EW'(m_er));
    raddr = 2'd0; #0.4; chk(tag, "sub_pend", rdata, EW'(m_sp));
    raddr = 2'd1; #0.4; chk(tag, "sub_mask", rdata, EW'(m_sm));
    raddr = 2'd2; #0.4; chk(tag, "ext_pend", rdata, m_ep);
    raddr = 2'd3; #0.4; chk(tag, "ext_mask", rdata, m_em);
  endtask

  // one cycle of stimulus, model update and check
  task automatic step(string tag, logic w, logic [1:0] a, logic [EW-1:0] d,
                      logic [SW-1:0] se, logic [EW-1:0] ee);
    logic [SW-1:0] n_sp, n_sm, s_clr;
    logic [EW-1:0] n_ep, n_em, e_clr;
    we = w; waddr = a; wdata = d; sub_evt = se; ext_evt = ee;
    s_clr = (w && a == 2'd0) ? d[SW-1:0] : '0;
    e_clr = (w && a == 2'd2) ? d : '0;
    n_sp = (m_sp & ~s_clr) | se;
    n_ep = (m_ep & ~e_clr) | ee;
    n_sm = (w && a == 2'd1) ? d[SW-1:0] : m_sm;
    n_em = (w && a == 2'd3) ? d : m_em;
    @(posedge clk);
    m_sr = f_sub_req(m_sp, m_sm);
    m_er = f_ext_req(m_ep, m_em);
    m_sp = n_sp; m_ep = n_ep; m_sm = n_sm; m_em = n_em;
    @(negedge clk);
    we = 1'b0; sub_evt = '0; ext_evt = '0;
    check_all(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 2'd0, '0, '0, '0);
  endtask

  initial begin
    #(8.0 * 200000);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_sp = '0; m_ep = '0; m_sm = '1; m_em = '1; m_sr = '0; m_er = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2: event on a masked sub-source sets pending, no request
    step("R2", 1'b0, 2'd0, '0, 15'h0010, '0);
    idle("R2");
    // R5: unmask bit 4 only
    step("R5", 1'b1, 2'd1, EW'(15'h7FEF), '0, '0);
    // R7: bit 4 lands on group 1 one edge later
    idle("R7");
    chk("R7", "sub_req grp1", EW'(sub_req), EW'(5'b00010));
    // R9: request holds while the pending bit stays
    idle("R9"); idle("R9");
    // R3: writing zeros clears nothing
    step("R3", 1'b1, 2'd0, '0, '0, '0);
    // R3: writing one clears bit 4
    step("R3", 1'b1, 2'd0, EW'(15'h0010), '0, '0);
    idle("R9");
    chk("R9", "sub_req dropped", EW'(sub_req), '0);
    // R4: event and clear on the same bit in the same cycle
    step("R4", 1'b1, 2'd0, EW'(15'h0010), 15'h0010, '0);
    chk("R4", "sub_pend bit4", rdata, m_em); // rdata is ext mask read here
    step("R4", 1'b1, 2'd0, EW'(15'h0010), '0, '0);
    // R8: external grouping
    step("R8", 1'b1, 2'd3, '0, '0, '0);
    step("R8", 1'b0, 2'd0, '0, '0, 20'h00002);
    idle("R8");
    chk("R8", "ext_req lines 4-7", EW'(ext_req), EW'(2'b01));
    step("R8", 1'b1, 2'd2, 20'h00002, '0, 20'h10000);
    idle("R8");
    chk("R8", "ext_req lines 8-23", EW'(ext_req), EW'(2'b10));
    step("R3", 1'b1, 2'd2, 20'hFFFFF, '0, '0);

    // R6: constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic          w;
      logic [1:0]    a;
      logic [EW-1:0] d;
      logic [SW-1:0] se;
      logic [EW-1:0] ee;
      w  = ($urandom % 3) == 0;
      a  = 2'($urandom % 4);
      d  = EW'($urandom) & EW'($urandom);
      se = (($urandom % 4) == 0) ? SW'(1 << ($urandom % SW)) : '0;
      ee = (($urandom % 4) == 0) ? EW'(1 << ($urandom % EW)) : '0;
      if ((a == 2'd1 || a == 2'd3) && ($urandom % 2 == 0)) d = d | (d << 1);
      step("R6", w, a, d, se, ee);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule